// File: doc/BRIEF.md
# Bit-Oriented Code Transceiver

This block sends and recognises the short repeating priority messages carried in the data-link bit positions of an extended-superframe stream. Each message is a 6-bit code placed inside a fixed 16-slot pattern. On the send side, the host sets a code and raises a send enable. The block then repeats the pattern for as long as the enable stays high. It advances one slot each time the framer strobes a data-link bit out. When the enable is low, the block fills the link with ones.

On the receive side, the framer presents each data-link bit with a strobe. The block slides a 16-bit window over this stream to find a valid pattern. It then keeps checking at the same alignment, once every 16 bits. A code is announced only after the same value has arrived three times in a row. The loss of that code is announced as a separate one-clock event.

All slot positions below count from 0, in the order the slots go onto the link. Slots 0..7 are ones, slot 8 is a zero, slots 9..14 carry code bits 0..5 (least significant bit first), and slot 15 is a zero.

Top module: `boc_xcvr`

## Requirements
- R1: With send enabled, `tx_bit` presents the 16-slot pattern for the latched code, repeated back to back. When sending starts from idle, the first slot taken by `tx_strobe` while `tx_enable` is high is slot 0 of a pattern.
- R2: While idle, `tx_bit` is 1. If `tx_enable` falls in the middle of a pattern, the rest of that pattern is still sent, and then `tx_bit` returns to ones.
- R3: `tx_code` is sampled only at the strobe that starts a pattern. This is the strobe that takes slot 15 of the previous pattern, or the starting strobe from idle. A change in mid-pattern therefore appears from the next pattern onwards.
- R4: `tx_bit` changes only in the clock after a cycle in which `tx_strobe` is high.
- R5: `rx_bit` is used only in cycles where `rx_strobe` is high. Receive events occur only in the clock after a receive strobe.
- R6: When the same code arrives in three consecutive valid patterns, each 16 strobes apart, the following happen in the clock after the strobe that completes the third pattern:
  - `det_event` pulses for one clock;
  - `det_code` takes the code;
  - `det_valid` rises.
- R7: Before acceptance, the run of repeats is handled as follows at each 16-bit check:
  - an invalid window discards the run;
  - a valid window carrying a different code restarts the count at one, for that new code.
- R8: While `det_valid` is high, the accepted pattern is checked every 16 strobes:
  - two consecutive checks without the accepted pattern give a one-clock `cease_event` and drop `det_valid`;
  - a single failing check followed by a match gives no event.
- R9: If the window that causes a cease is itself a valid pattern with another code, it counts as the first of three repeats for that code.
- R10: `det_event` and `cease_event` never occur together. `det_event` occurs exactly when `det_valid` rises, and `cease_event` exactly when it falls. `det_code` does not change while `det_valid` stays high.
- R11: After reset, `tx_bit` is 1, `det_valid`, `det_event` and `cease_event` are 0, and `det_code` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_code | input | 6 | Code to send |
| tx_enable | input | 1 | Keep sending the code pattern |
| tx_strobe | input | 1 | One transmit data-link slot is taken this cycle |
| tx_bit | output | 1 | Transmit data-link bit for the current slot |
| rx_strobe | input | 1 | A receive data-link bit is valid this cycle |
| rx_bit | input | 1 | Receive data-link bit |
| det_code | output | 6 | Last accepted code |
| det_valid | output | 1 | An accepted code is currently arriving |
| det_event | output | 1 | One-clock pulse when a code is accepted |
| cease_event | output | 1 | One-clock pulse when the accepted code stops |

## Verification
The assertions are checked on every cycle. They cover the timing rules that hold on every cycle:
- the transmit bit holds steady between strobes;
- receive events follow only receive strobes;
- each event pairs with the matching edge of `det_valid`, and the two events exclude each other;
- the accepted code stays stable while it is valid.

Other behaviour can only be shown by the bench's directed scenarios, which track the bit stream over time: the exact slot contents, when a code change or a disable takes effect, the count of three repeats, the reset of a broken run, the cease after two misses, and reseeding from a ceasing window. A loopback scenario ties the transmitter to the receiver to show that the two halves agree on the pattern.

// File: rtl/boc_pkg.sv
package boc_pkg;

    localparam int BOC_CODE_W = 6;
    localparam int BOC_FLAG_W = 8;
    // flag run, one separator zero, code bits, one closing zero
    localparam int BOC_PAT_W  = BOC_FLAG_W + BOC_CODE_W + 2;
    localparam int BOC_IDX_W  = $clog2(BOC_PAT_W);

    typedef logic [BOC_CODE_W-1:0] boc_code_t;
    typedef logic [BOC_IDX_W-1:0]  boc_idx_t;
    typedef logic [BOC_PAT_W-1:0]  boc_win_t;

    typedef struct packed {
        logic      sending;
        boc_idx_t  idx;
        boc_code_t code;
    } boc_tx_state_t;

    typedef struct packed {
        logic      hit;
        boc_code_t code;
    } boc_look_t;

    typedef struct packed {
        logic      valid;
        boc_code_t code;
        logic      det;
        logic      cease;
    } boc_report_t;

    typedef enum logic [1:0] {
        RX_HUNT = 2'd0,
        RX_QUAL = 2'd1,
        RX_LOCK = 2'd2
    } boc_rx_state_e;

    // Value of one slot of the pattern; slot 0 goes onto the link first.
    function automatic logic boc_slot_bit(input boc_code_t c, input boc_idx_t idx);
        int k;
        k = int'(idx);
        if (k < BOC_FLAG_W)
            return 1'b1;
        else if (k == BOC_FLAG_W)
            return 1'b0;
        else if (k <= BOC_FLAG_W + BOC_CODE_W)
            return c[k - BOC_FLAG_W - 1];
        else
            return 1'b0;
    endfunction

    // Decode a receive window; the oldest bit sits at the MSB.
    function automatic boc_look_t boc_decode(input boc_win_t win);
        boc_look_t r;
        r.hit  = 1'b1;
        r.code = '0;
        for (int i = 0; i < BOC_FLAG_W; i++) begin
            if (!win[BOC_PAT_W-1-i])
                r.hit = 1'b0;
        end
        if (win[BOC_PAT_W-1-BOC_FLAG_W])
            r.hit = 1'b0;
        for (int j = 0; j < BOC_CODE_W; j++) begin
            r.code[j] = win[BOC_PAT_W-2-BOC_FLAG_W-j];
        end
        if (win[0])
            r.hit = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/boc_tx.sv
module boc_tx
    import boc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      strobe,
    input  logic      enable,
    input  boc_code_t code_in,
    output logic      bit_out
);

    localparam boc_idx_t LAST_IDX = boc_idx_t'(BOC_PAT_W - 1);

    boc_tx_state_t st_q, st_n;

    always_comb begin
        st_n = st_q;
        if (strobe) begin
            if (st_q.sending) begin
                if (st_q.idx == LAST_IDX) begin
                    st_n.idx = '0;
                    if (enable)
                        st_n.code = code_in;   // R3: sample at pattern start
                    else
                        st_n.sending = 1'b0;   // R2: finish pattern, then idle
                end else begin
                    st_n.idx = st_q.idx + 1'b1;
                end
            end else if (enable) begin
                // idle slot equals slot 0 (a one); the pattern continues at slot 1
                st_n.sending = 1'b1;
                st_n.idx     = boc_idx_t'(1);
                st_n.code    = code_in;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '{sending: 1'b0, idx: '0, code: '0};
        else
            st_q <= st_n;
    end

    always_comb begin
        if (st_q.sending)
            bit_out = boc_slot_bit(st_q.code, st_q.idx);
        else
            bit_out = 1'b1;
    end

endmodule

// File: rtl/boc_rx_window.sv
module boc_rx_window
    import boc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      strobe,
    input  logic      bit_in,
    output boc_look_t look
);

    boc_win_t win_q;
    boc_win_t win_n;

    assign win_n = {win_q[BOC_PAT_W-2:0], bit_in};

    always_ff @(posedge clk) begin
        if (rst)
            win_q <= '0;
        else if (strobe)
            win_q <= win_n;
    end

    // decode of the window including the bit being strobed now
    assign look = boc_decode(win_n);

endmodule

// File: rtl/boc_rx_qual.sv
module boc_rx_qual
    import boc_pkg::*;
#(
    parameter int QUAL_REPEAT = 3,
    parameter int CEASE_MISS  = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        strobe,
    input  boc_look_t   look,
    output boc_report_t rpt
);

    localparam int REP_W  = $clog2(QUAL_REPEAT + 1);
    localparam int MISS_W = $clog2(CEASE_MISS + 1);
    localparam boc_idx_t LAST_IDX = boc_idx_t'(BOC_PAT_W - 1);

    boc_rx_state_e     st_q, st_n;
    boc_idx_t          cnt_q, cnt_n;
    boc_code_t         cand_q, cand_n;
    logic [REP_W-1:0]  rep_q, rep_n;
    logic [MISS_W-1:0] miss_q, miss_n;
    boc_report_t       rpt_q, rpt_n;

    logic at_edge;
    logic same_cand;
    logic same_held;

    assign at_edge   = (cnt_q == LAST_IDX);
    assign same_cand = look.hit && (look.code == cand_q);
    assign same_held = look.hit && (look.code == rpt_q.code);

    always_comb begin
        st_n        = st_q;
        cnt_n       = cnt_q;
        cand_n      = cand_q;
        rep_n       = rep_q;
        miss_n      = miss_q;
        rpt_n       = rpt_q;
        rpt_n.det   = 1'b0;
        rpt_n.cease = 1'b0;
        if (strobe) begin
            unique case (st_q)
                RX_HUNT: begin
                    if (look.hit) begin
                        st_n   = RX_QUAL;
                        cand_n = look.code;
                        rep_n  = REP_W'(1);
                        cnt_n  = '0;
                    end
                end
                RX_QUAL: begin
                    if (!at_edge) begin
                        cnt_n = cnt_q + 1'b1;
                    end else begin
                        cnt_n = '0;
                        if (same_cand) begin
                            if (rep_q == REP_W'(QUAL_REPEAT - 1)) begin
                                st_n       = RX_LOCK;
                                rpt_n.valid = 1'b1;
                                rpt_n.code  = cand_q;
                                rpt_n.det   = 1'b1;
                                miss_n     = '0;
                            end else begin
                                rep_n = rep_q + 1'b1;
                            end
                        end else if (look.hit) begin
                            cand_n = look.code;
                            rep_n  = REP_W'(1);
                        end else begin
                            st_n = RX_HUNT;
                        end
                    end
                end
                RX_LOCK: begin
                    if (!at_edge) begin
                        cnt_n = cnt_q + 1'b1;
                    end else begin
                        cnt_n = '0;
                        if (same_held) begin
                            miss_n = '0;
                        end else if (miss_q == MISS_W'(CEASE_MISS - 1)) begin
                            rpt_n.valid = 1'b0;
                            rpt_n.cease = 1'b1;
                            miss_n      = '0;
                            if (look.hit) begin
                                st_n   = RX_QUAL;
                                cand_n = look.code;
                                rep_n  = REP_W'(1);
                            end else begin
                                st_n = RX_HUNT;
                            end
                        end else begin
                            miss_n = miss_q + 1'b1;
                        end
                    end
                end
                default: st_n = RX_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= RX_HUNT;
            cnt_q  <= '0;
            cand_q <= '0;
            rep_q  <= '0;
            miss_q <= '0;
            rpt_q  <= '{valid: 1'b0, code: '0, det: 1'b0, cease: 1'b0};
        end else begin
            st_q   <= st_n;
            cnt_q  <= cnt_n;
            cand_q <= cand_n;
            rep_q  <= rep_n;
            miss_q <= miss_n;
            rpt_q  <= rpt_n;
        end
    end

    assign rpt = rpt_q;

endmodule

// File: rtl/boc_xcvr.sv
module boc_xcvr
    import boc_pkg::*;
#(
    parameter int QUAL_REPEAT = 3,
    parameter int CEASE_MISS  = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [BOC_CODE_W-1:0] tx_code,
    input  logic                  tx_enable,
    input  logic                  tx_strobe,
    output logic                  tx_bit,
    input  logic                  rx_strobe,
    input  logic                  rx_bit,
    output logic [BOC_CODE_W-1:0] det_code,
    output logic                  det_valid,
    output logic                  det_event,
    output logic                  cease_event
);

    boc_look_t   look;
    boc_report_t rpt;

    boc_tx u_tx (
        .clk     (clk),
        .rst     (rst),
        .strobe  (tx_strobe),
        .enable  (tx_enable),
        .code_in (tx_code),
        .bit_out (tx_bit)
    );

    boc_rx_window u_win (
        .clk    (clk),
        .rst    (rst),
        .strobe (rx_strobe),
        .bit_in (rx_bit),
        .look   (look)
    );

    boc_rx_qual #(
        .QUAL_REPEAT (QUAL_REPEAT),
        .CEASE_MISS  (CEASE_MISS)
    ) u_qual (
        .clk    (clk),
        .rst    (rst),
        .strobe (rx_strobe),
        .look   (look),
        .rpt    (rpt)
    );

    assign det_code    = rpt.code;
    assign det_valid   = rpt.valid;
    assign det_event   = rpt.det;
    assign cease_event = rpt.cease;

endmodule

// File: rtl/boc_xcvr_chk.sv
module boc_xcvr_chk
    import boc_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic [BOC_CODE_W-1:0] tx_code,
    input logic                  tx_enable,
    input logic                  tx_strobe,
    input logic                  tx_bit,
    input logic                  rx_strobe,
    input logic                  rx_bit,
    input logic [BOC_CODE_W-1:0] det_code,
    input logic                  det_valid,
    input logic                  det_event,
    input logic                  cease_event
);

    assert_tx_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !tx_strobe |=> $stable(tx_bit));

    assert_rx_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        !rx_strobe |=> (!det_event && !cease_event));

    assert_det_edge_R6: assert property (@(posedge clk) disable iff (rst)
        det_event |-> $rose(det_valid));

    assert_cease_edge_R8: assert property (@(posedge clk) disable iff (rst)
        cease_event |-> $fell(det_valid));

    assert_valid_rise_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(det_valid) |-> det_event);

    assert_valid_fall_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(det_valid) |-> cease_event);

    assert_events_apart_R10: assert property (@(posedge clk) disable iff (rst)
        !(det_event && cease_event));

    assert_code_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (det_valid && !det_event) |-> $stable(det_code));

    assert_reset_state_R11: assert property (@(posedge clk)
        rst |=> (tx_bit && !det_valid && !det_event && !cease_event));

endmodule

bind boc_xcvr boc_xcvr_chk u_chk (.*);

// File: tb/boc_xcvr_test.sv
module boc_xcvr_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] tx_code = '0;
    logic       tx_enable = 1'b0;
    logic       tx_strobe = 1'b0;
    logic       tx_bit;
    logic       rx_strobe_d = 1'b0;
    logic       rx_drv = 1'b0;
    logic       loop_on = 1'b0;
    logic       rx_strobe;
    logic       rx_bit;
    logic [5:0] det_code;
    logic       det_valid;
    logic       det_event;
    logic       cease_event;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    assign rx_strobe = loop_on ? tx_strobe : rx_strobe_d;
    assign rx_bit    = loop_on ? tx_bit    : rx_drv;

    boc_xcvr uut (
        .clk         (clk),
        .rst         (rst),
        .tx_code     (tx_code),
        .tx_enable   (tx_enable),
        .tx_strobe   (tx_strobe),
        .tx_bit      (tx_bit),
        .rx_strobe   (rx_strobe),
        .rx_bit      (rx_bit),
        .det_code    (det_code),
        .det_valid   (det_valid),
        .det_event   (det_event),
        .cease_event (cease_event)
    );

    // Expected pattern, slot i at bit i.
    function automatic logic [15:0] ref_pat(input logic [5:0] c);
        return {1'b0, c, 1'b0, 8'hFF};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tx_enable = 1'b0;
        tx_strobe = 1'b0;
        rx_strobe_d = 1'b0;
        loop_on = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // One strobe cycle. Called at a negedge and returns at the next one.
    task automatic step(input logic ts, input logic rs, input logic rb,
                        output logic txb, output logic de, output logic ce);
        txb = tx_bit;
        tx_strobe = ts;
        rx_strobe_d = rs;
        rx_drv = rb;
        @(negedge clk);
        tx_strobe = 1'b0;
        rx_strobe_d = 1'b0;
        rx_drv = ~rb;   // wiggle with no strobe, must be ignored (R5)
        de = det_event;
        ce = cease_event;
    endtask

    // Feed 16 receive bits; count events and note events on the last bit.
    task automatic rx_window(input logic [15:0] slots, output int nd, output int nc,
                             output logic ld, output logic lc);
        logic txb, de, ce;
        nd = 0; nc = 0; ld = 0; lc = 0;
        for (int i = 0; i < 16; i++) begin
            step(1'b0, 1'b1, slots[i], txb, de, ce);
            nd += int'(de);
            nc += int'(ce);
            if (i == 15) begin
                ld = de;
                lc = ce;
            end
        end
    endtask

    // Collect one transmitted pattern, with optional mid-pattern actions.
    task automatic tx_collect(output logic [15:0] got, input int pause_at,
                              input int chg_at, input logic [5:0] chg_code,
                              input int dis_at);
        logic txb, de, ce, held;
        for (int i = 0; i < 16; i++) begin
            if (i == pause_at) begin
                held = tx_bit;
                repeat (4) @(negedge clk);
                check("R4 tx_bit held without strobe", int'(tx_bit), int'(held));
            end
            if (i == chg_at) tx_code = chg_code;
            if (i == dis_at) tx_enable = 1'b0;
            step(1'b1, 1'b0, 1'b0, txb, de, ce);
            got[i] = txb;
        end
    endtask

    task automatic t_reset();
        logic txb, de, ce;
        int ones;
        do_reset();
        check("R11 tx_bit after reset", int'(tx_bit), 1);
        check("R11 det_valid after reset", int'(det_valid), 0);
        check("R11 det_event after reset", int'(det_event), 0);
        check("R11 cease_event after reset", int'(cease_event), 0);
        check("R11 det_code after reset", int'(det_code), 0);
        ones = 0;
        for (int i = 0; i < 20; i++) begin
            step(1'b1, 1'b0, 1'b0, txb, de, ce);
            ones += int'(txb);
        end
        check("R2 idle slots all ones", ones, 20);
    endtask

    task automatic t_tx_stream();
        logic [15:0] got;
        int ones;
        logic txb, de, ce;
        tx_code = 6'b101101;
        tx_enable = 1'b1;
        tx_collect(got, -1, -1, 6'h00, -1);
        check("R1 first pattern", int'(got), int'(ref_pat(6'b101101)));
        tx_collect(got, 11, -1, 6'h00, -1);
        check("R1 repeated pattern", int'(got), int'(ref_pat(6'b101101)));
        tx_collect(got, -1, 5, 6'b010011, -1);
        check("R3 code change waits for boundary", int'(got), int'(ref_pat(6'b101101)));
        tx_collect(got, -1, -1, 6'h00, -1);
        check("R3 new code from next pattern", int'(got), int'(ref_pat(6'b010011)));
        tx_collect(got, -1, -1, 6'h00, 3);
        check("R2 pattern finished after disable", int'(got), int'(ref_pat(6'b010011)));
        ones = 0;
        for (int i = 0; i < 20; i++) begin
            step(1'b1, 1'b0, 1'b0, txb, de, ce);
            ones += int'(txb);
        end
        check("R2 ones after disable", ones, 20);
    endtask

    task automatic t_rx_detect();
        int nd, nc;
        logic ld, lc, txb, de, ce;
        logic [5:0] a;
        a = 6'h2A;
        do_reset();
        // leading noise: ones, then zero, then a short fragment
        for (int i = 0; i < 9; i++) step(1'b0, 1'b1, (i == 5) ? 1'b0 : 1'b1, txb, de, ce);
        rx_window(ref_pat(a), nd, nc, ld, lc);
        check("R6 no detect after one pattern", nd, 0);
        rx_window(ref_pat(a), nd, nc, ld, lc);
        check("R6 no detect after two patterns", nd, 0);
        check("R6 still not valid", int'(det_valid), 0);
        rx_window(ref_pat(a), nd, nc, ld, lc);
        check("R6 detect pulse count on third", nd, 1);
        check("R6 detect on last bit of third", int'(ld), 1);
        check("R6 det_valid after detect", int'(det_valid), 1);
        check("R6 det_code after detect", int'(det_code), int'(a));
        // R5: bits with no strobe leave the locked state alone
        for (int i = 0; i < 40; i++) begin
            rx_drv = i[0];
            @(negedge clk);
            nd += int'(det_event);
            nc += int'(cease_event);
        end
        check("R5 no events without strobe", nd + nc, 1);
        check("R5 still valid after unstrobed bits", int'(det_valid), 1);
    endtask

    task automatic t_rx_cease();
        int nd, nc;
        logic ld, lc;
        // locked on 6'h2A from t_rx_detect; window alignment continues
        rx_window(ref_pat(6'h2A), nd, nc, ld, lc);
        check("R8 matching window no event", nd + nc, 0);
        rx_window(16'hFFFF, nd, nc, ld, lc);
        check("R8 single miss no cease", nc, 0);
        rx_window(ref_pat(6'h2A), nd, nc, ld, lc);
        check("R8 recovery after one miss", nc, 0);
        check("R8 valid kept after one miss", int'(det_valid), 1);
        rx_window(16'hFFFF, nd, nc, ld, lc);
        check("R8 first of two misses", nc, 0);
        rx_window(16'hFFFF, nd, nc, ld, lc);
        check("R8 cease pulse count", nc, 1);
        check("R8 cease on last bit", int'(lc), 1);
        check("R8 det_valid dropped", int'(det_valid), 0);
    endtask

    task automatic t_rx_break();
        int nd, nc;
        logic ld, lc;
        logic [5:0] a, b;
        a = 6'h15;
        b = 6'h00;
        do_reset();
        rx_window(ref_pat(a), nd, nc, ld, lc);
        rx_window(ref_pat(a), nd, nc, ld, lc);
        rx_window(ref_pat(b), nd, nc, ld, lc);
        check("R7 other code restarts run", nd, 0);
        rx_window(ref_pat(b), nd, nc, ld, lc);
        check("R7 two of new code no detect", nd, 0);
        rx_window(ref_pat(b), nd, nc, ld, lc);
        check("R7 third of new code detects", int'(ld), 1);
        check("R7 detected code is the new one", int'(det_code), int'(b));
        do_reset();
        rx_window(ref_pat(a), nd, nc, ld, lc);
        rx_window(ref_pat(a), nd, nc, ld, lc);
        rx_window(16'h0000, nd, nc, ld, lc);
        rx_window(ref_pat(a), nd, nc, ld, lc);
        check("R7 invalid window discards run", nd, 0);
        rx_window(ref_pat(a), nd, nc, ld, lc);
        check("R7 two after break no detect", nd, 0);
        check("R7 not valid after break", int'(det_valid), 0);
    endtask

    task automatic t_rx_switch();
        int nd, nc;
        logic ld, lc;
        logic [5:0] a, b;
        a = 6'h09;
        b = 6'h36;
        do_reset();
        for (int i = 0; i < 3; i++) rx_window(ref_pat(a), nd, nc, ld, lc);
        check("R9 locked on first code", int'(det_code), int'(a));
        rx_window(ref_pat(b), nd, nc, ld, lc);
        check("R9 first other window no cease", nc, 0);
        rx_window(ref_pat(b), nd, nc, ld, lc);
        check("R9 second other window ceases", int'(lc), 1);
        rx_window(ref_pat(b), nd, nc, ld, lc);
        check("R9 no detect yet", nd, 0);
        rx_window(ref_pat(b), nd, nc, ld, lc);
        check("R9 ceasing window counted as first", int'(ld), 1);
        check("R9 new code reported", int'(det_code), int'(b));
    endtask

    task automatic t_loopback();
        logic txb, de, ce;
        int nd;
        int at;
        do_reset();
        loop_on = 1'b1;
        tx_code = 6'h3F;
        tx_enable = 1'b1;
        nd = 0;
        at = -1;
        for (int i = 0; i < 48; i++) begin
            step(1'b1, 1'b0, 1'b0, txb, de, ce);
            if (de) begin
                nd++;
                at = i;
            end
        end
        check("R1 loopback detect count", nd, 1);
        check("R6 loopback detect after third pattern", at, 47);
        check("R6 loopback code all ones", int'(det_code), 63);
        tx_enable = 1'b0;
        loop_on = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_tx_stream();
        t_rx_detect();
        t_rx_cease();
        t_rx_break();
        t_rx_switch();
        t_loopback();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule